// File: doc/BRIEF.md
# Lane Allocator and Link Arbiter

This block sits on the transmitting side of one physical link that carries several virtual lanes. For each lane at the receiver it keeps a status entry. The entry holds a busy/free flag, the number of flit slots still open at the receiver (its credit count), the priority of the packet that owns the lane, and an allocation timestamp.

A new packet that wants this output link raises `allocReq`. In the same cycle it receives the lowest-numbered free lane. If every lane is taken, the grant stays low and the packet has to keep asking. Each cycle the block also picks at most one lane to put a flit on the link. A lane can be picked only when it is owned by a packet, has a flit waiting, and has at least one credit. The `mode` input selects how the pick is made: plain rotation, highest packet priority, or oldest allocation. Credits come back as single pulses tagged with a lane number. When the last flit of a packet goes out, its lane is released.

Top module: `lane_tx_arbiter`

## Requirements
- R1: After reset every lane is free, every credit count equals LANE_DEPTH, `creditErr` is 0 and `sendValid` is 0.
- R2: When `allocReq` is high and some lane is free, `allocGrant` is 1 in the same cycle and `allocLane` is the lowest-numbered free lane. From the next cycle that lane reads busy on `laneFree`.
- R3: When `allocReq` is low or no lane is free, `allocGrant` is 0.
- R4: `sendValid` is 1 only for a lane that is busy, has `flitReady` set and has a nonzero credit count. At most one lane is sent per cycle, and a free lane is never sent.
- R5: With `mode` = 0 (and also with the unused value 3), the lanes are scanned from a rotating pointer and the first eligible lane is sent. After each send the pointer moves to the lane after the one sent, wrapping from the top lane to lane 0.
- R6: With `mode` = 1, the eligible lane with the largest priority value (taken from `allocPrio` at allocation) is sent. Equal priorities are resolved in the rotation order of R5.
- R7: With `mode` = 2, the eligible lane that was allocated earliest is sent. Age is the allocation counter minus the lane's stored stamp, computed modulo 2^STAMP_W. Ties are resolved in rotation order.
- R8: A send lowers the sent lane's count by one. A `creditValid` pulse raises the count of the lane numbered `creditLane` by one. Both on the same lane in the same cycle leave the count unchanged. Lane i's count appears on `laneCredit[i*CW +: CW]`, where CW = $clog2(LANE_DEPTH+1).
- R9: A send with `flitLast` set for the sent lane makes that lane free from the next cycle.
- R10: A credit pulse, with no send on that lane, to a lane whose count already equals LANE_DEPTH leaves the count unchanged and sets `creditErr`. `creditErr` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Link pick policy: 0 rotate, 1 priority, 2 oldest, 3 rotate |
| allocReq | input | 1 | A new packet requests a lane |
| allocPrio | input | PRIO_W | Priority of the requesting packet |
| allocGrant | output | 1 | Lane granted this cycle |
| allocLane | output | $clog2(NUM_LANES) | Granted lane number |
| flitReady | input | NUM_LANES | Lane has a flit waiting |
| flitLast | input | NUM_LANES | The waiting flit is its packet's last |
| sendValid | output | 1 | A flit goes on the link this cycle |
| sendLane | output | $clog2(NUM_LANES) | Lane whose flit is sent |
| creditValid | input | 1 | Receiver returned one flit slot |
| creditLane | input | $clog2(NUM_LANES) | Lane the returned slot belongs to |
| laneFree | output | NUM_LANES | Per-lane free flag |
| laneCredit | output | NUM_LANES*CW | Per-lane credit counts, packed |
| creditErr | output | 1 | Sticky credit overflow flag |

## Verification
The bench builds the block with its defaults: four lanes, a depth of four credits, 2-bit priorities and 8-bit stamps. With a depth of four, a single lane runs out of credit within a few sends, so the stall on an empty count and the overflow from an extra credit both occur in short sequences. With four lanes, the rotating pointer wraps past an unallocated lane, and the allocator runs out of lanes, within a short vector table. Stamp wraparound is not reached at these sizes.

// File: rtl/lane_arb_pkg.sv
package lane_arb_pkg;
  typedef enum logic [1:0] {
    ARB_RR   = 2'd0,
    ARB_PRIO = 2'd1,
    ARB_AGE  = 2'd2,
    ARB_RSVD = 2'd3
  } arbMode_e;

  // strobes from control to the lane status datapath
  typedef struct packed {
    logic allocFire;
    logic sendFire;
    logic sendLast;
  } ctrlStrobe_t;
endpackage

// File: rtl/lane_arb_dpath.sv
module lane_arb_dpath
  import lane_arb_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LANE_DEPTH = 4,
  parameter int PRIO_W     = 2,
  parameter int STAMP_W    = 8,
  localparam int LW = $clog2(NUM_LANES),
  localparam int CW = $clog2(LANE_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrlStrobe_t             strobes,
  input  logic [LW-1:0]           allocIdx,
  input  logic [LW-1:0]           sendIdx,
  input  logic [PRIO_W-1:0]       allocPrio,
  input  logic                    creditValid,
  input  logic [LW-1:0]           creditLane,
  output logic [NUM_LANES-1:0]    laneFree,
  output logic [NUM_LANES-1:0]    credNz,
  output logic [PRIO_W-1:0]       lanePrio  [NUM_LANES],
  output logic [STAMP_W-1:0]      laneStamp [NUM_LANES],
  output logic [STAMP_W-1:0]      stampNow,
  output logic [NUM_LANES*CW-1:0] laneCreditFlat,
  output logic                    creditErr
);
  localparam logic [CW-1:0] FULL = CW'(LANE_DEPTH);

  logic [CW-1:0] credit [NUM_LANES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        laneFree[i]  <= 1'b1;
        credit[i]    <= FULL;
        lanePrio[i]  <= '0;
        laneStamp[i] <= '0;
      end
      stampNow  <= '0;
      creditErr <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) begin
        logic takeIt, sendIt, backIt;
        takeIt = strobes.allocFire && (allocIdx == LW'(i));
        sendIt = strobes.sendFire && (sendIdx == LW'(i));
        backIt = creditValid && (creditLane == LW'(i));
        if (takeIt) begin
          laneFree[i]  <= 1'b0;
          lanePrio[i]  <= allocPrio;
          laneStamp[i] <= stampNow;
        end else if (sendIt && strobes.sendLast) begin
          laneFree[i] <= 1'b1;
        end
        if (backIt && !sendIt) begin
          if (credit[i] == FULL) creditErr <= 1'b1;
          else                   credit[i] <= credit[i] + 1'b1;
        end else if (sendIt && !backIt) begin
          credit[i] <= credit[i] - 1'b1;
        end
      end
      if (strobes.allocFire) stampNow <= stampNow + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++) begin
      credNz[i] = (credit[i] != '0);
      laneCreditFlat[i*CW +: CW] = credit[i];
    end
  end
endmodule

// File: rtl/lane_arb_ctrl.sv
module lane_arb_ctrl
  import lane_arb_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int PRIO_W    = 2,
  parameter int STAMP_W   = 8,
  localparam int LW    = $clog2(NUM_LANES),
  localparam int KEY_W = (PRIO_W > STAMP_W) ? PRIO_W : STAMP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 allocReq,
  input  logic [NUM_LANES-1:0] flitReady,
  input  logic [NUM_LANES-1:0] flitLast,
  input  logic [NUM_LANES-1:0] laneFree,
  input  logic [NUM_LANES-1:0] credNz,
  input  logic [PRIO_W-1:0]    lanePrio  [NUM_LANES],
  input  logic [STAMP_W-1:0]   laneStamp [NUM_LANES],
  input  logic [STAMP_W-1:0]   stampNow,
  output ctrlStrobe_t          strobes,
  output logic [LW-1:0]        allocIdx,
  output logic [LW-1:0]        sendIdx
);
  logic [LW-1:0]        rrPtr;
  logic [NUM_LANES-1:0] eligible;
  logic                 allocFound;
  logic                 bestFound;
  logic [LW-1:0]        bestIdx;
  logic [KEY_W-1:0]     bestKey;
  logic [KEY_W-1:0]     key;
  int                   idx;

  // lowest free lane wins the allocation
  always_comb begin
    allocFound = 1'b0;
    allocIdx   = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (laneFree[i]) begin
        allocFound = 1'b1;
        allocIdx   = LW'(i);
      end
    end
  end

  assign eligible = ~laneFree & flitReady & credNz;

  // scan in rotation order, replace only on a strictly better key
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestKey   = '0;
    idx       = 0;
    key       = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= NUM_LANES) idx = idx - NUM_LANES;
      case (arbMode_e'(mode))
        ARB_PRIO: key = KEY_W'(lanePrio[idx]);
        ARB_AGE:  key = KEY_W'(STAMP_W'(stampNow - laneStamp[idx]));
        default:  key = '0;
      endcase
      if (eligible[idx] && (!bestFound || key > bestKey)) begin
        bestFound = 1'b1;
        bestIdx   = LW'(idx);
        bestKey   = key;
      end
    end
  end

  always_comb begin
    strobes.allocFire = allocReq && allocFound;
    strobes.sendFire  = bestFound;
    strobes.sendLast  = bestFound && flitLast[bestIdx];
    sendIdx           = bestIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rrPtr <= '0;
    else if (bestFound)
      rrPtr <= (bestIdx == LW'(NUM_LANES - 1)) ? '0 : bestIdx + 1'b1;
  end
endmodule

// File: rtl/lane_tx_arbiter.sv
module lane_tx_arbiter
  import lane_arb_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int LANE_DEPTH = 4,
  parameter int PRIO_W     = 2,
  parameter int STAMP_W    = 8,
  localparam int LW = $clog2(NUM_LANES),
  localparam int CW = $clog2(LANE_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    allocReq,
  input  logic [PRIO_W-1:0]       allocPrio,
  output logic                    allocGrant,
  output logic [LW-1:0]           allocLane,
  input  logic [NUM_LANES-1:0]    flitReady,
  input  logic [NUM_LANES-1:0]    flitLast,
  output logic                    sendValid,
  output logic [LW-1:0]           sendLane,
  input  logic                    creditValid,
  input  logic [LW-1:0]           creditLane,
  output logic [NUM_LANES-1:0]    laneFree,
  output logic [NUM_LANES*CW-1:0] laneCredit,
  output logic                    creditErr
);
  ctrlStrobe_t          strobes;
  logic [LW-1:0]        allocIdx;
  logic [LW-1:0]        sendIdx;
  logic [NUM_LANES-1:0] credNz;
  logic [PRIO_W-1:0]    lanePrio  [NUM_LANES];
  logic [STAMP_W-1:0]   laneStamp [NUM_LANES];
  logic [STAMP_W-1:0]   stampNow;

  lane_arb_ctrl #(
    .NUM_LANES(NUM_LANES), .PRIO_W(PRIO_W), .STAMP_W(STAMP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .allocReq(allocReq),
    .flitReady(flitReady), .flitLast(flitLast), .laneFree(laneFree),
    .credNz(credNz), .lanePrio(lanePrio), .laneStamp(laneStamp),
    .stampNow(stampNow), .strobes(strobes), .allocIdx(allocIdx),
    .sendIdx(sendIdx)
  );

  lane_arb_dpath #(
    .NUM_LANES(NUM_LANES), .LANE_DEPTH(LANE_DEPTH),
    .PRIO_W(PRIO_W), .STAMP_W(STAMP_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .allocIdx(allocIdx),
    .sendIdx(sendIdx), .allocPrio(allocPrio), .creditValid(creditValid),
    .creditLane(creditLane), .laneFree(laneFree), .credNz(credNz),
    .lanePrio(lanePrio), .laneStamp(laneStamp), .stampNow(stampNow),
    .laneCreditFlat(laneCredit), .creditErr(creditErr)
  );

  assign allocGrant = strobes.allocFire;
  assign allocLane  = allocIdx;
  assign sendValid  = strobes.sendFire;
  assign sendLane   = sendIdx;
endmodule

// File: rtl/lane_tx_arbiter_chk.sv
module lane_tx_arbiter_chk #(
  parameter int NUM_LANES  = 4,
  parameter int LANE_DEPTH = 4,
  parameter int PRIO_W     = 2,
  localparam int LW = $clog2(NUM_LANES),
  localparam int CW = $clog2(LANE_DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    allocReq,
  input logic                    allocGrant,
  input logic [LW-1:0]           allocLane,
  input logic [NUM_LANES-1:0]    flitReady,
  input logic [NUM_LANES-1:0]    flitLast,
  input logic                    sendValid,
  input logic [LW-1:0]           sendLane,
  input logic [NUM_LANES-1:0]    laneFree,
  input logic [NUM_LANES*CW-1:0] laneCredit,
  input logic                    creditErr
);
  logic [CW-1:0]        sendCred;
  logic [NUM_LANES-1:0] lowerMask;
  logic                 prevGrant, prevRelease;
  logic [LW-1:0]        prevAllocLane, prevSendLane;

  always_comb begin
    sendCred  = laneCredit[sendLane*CW +: CW];
    lowerMask = (NUM_LANES'(1) << allocLane) - NUM_LANES'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevGrant <= 1'b0; prevRelease <= 1'b0;
      prevAllocLane <= '0; prevSendLane <= '0;
    end else begin
      prevGrant     <= allocGrant;
      prevAllocLane <= allocLane;
      prevRelease   <= sendValid && flitLast[sendLane];
      prevSendLane  <= sendLane;
    end
  end

  // R2
  alloc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    allocGrant |-> (laneFree[allocLane] && ((laneFree & lowerMask) == '0)));
  // R2
  alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prevGrant |-> !laneFree[prevAllocLane]);
  // R3
  alloc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!allocReq || laneFree == '0) |-> !allocGrant);
  // R2
  alloc_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (allocReq && laneFree != '0) |-> allocGrant);
  // R4
  send_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sendValid |-> (flitReady[sendLane] && !laneFree[sendLane] && sendCred != '0));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prevRelease |-> laneFree[prevSendLane]);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    creditErr |=> creditErr);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_cred
    // R8
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      laneCredit[g*CW +: CW] <= CW'(LANE_DEPTH));
  end
endmodule

bind lane_tx_arbiter lane_tx_arbiter_chk #(
  .NUM_LANES(NUM_LANES), .LANE_DEPTH(LANE_DEPTH), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .allocReq(allocReq), .allocGrant(allocGrant),
  .allocLane(allocLane), .flitReady(flitReady), .flitLast(flitLast),
  .sendValid(sendValid), .sendLane(sendLane), .laneFree(laneFree),
  .laneCredit(laneCredit), .creditErr(creditErr)
);

// File: tb/lane_tx_arbiter_tb.sv
module lane_tx_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       allocReq;
  logic [1:0] allocPrio;
  logic       allocGrant;
  logic [1:0] allocLane;
  logic [3:0] flitReady, flitLast;
  logic       sendValid;
  logic [1:0] sendLane;
  logic       creditValid;
  logic [1:0] creditLane;
  logic [3:0] laneFree;
  logic [11:0] laneCredit;
  logic       creditErr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lane_tx_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .allocReq(allocReq),
    .allocPrio(allocPrio), .allocGrant(allocGrant), .allocLane(allocLane),
    .flitReady(flitReady), .flitLast(flitLast), .sendValid(sendValid),
    .sendLane(sendLane), .creditValid(creditValid), .creditLane(creditLane),
    .laneFree(laneFree), .laneCredit(laneCredit), .creditErr(creditErr)
  );

  typedef struct packed {
    logic       req;
    logic [1:0] prio;
    logic [1:0] md;
    logic [3:0] rdy;
    logic [3:0] lst;
    logic       cv;
    logic [1:0] cl;
    logic       expG;
    logic [1:0] expGL;
    logic       expS;
    logic [1:0] expSL;
  } vec_t;

  // R2 R3 R4 R5 R6 R7 R8 R9 exercised by this sequence
  localparam vec_t VECS [14] = '{
    '{1'b1, 2'd1, 2'd0, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 2'd0},
    '{1'b1, 2'd3, 2'd0, 4'b0001, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 2'd0},
    '{1'b1, 2'd2, 2'd0, 4'b0011, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd2, 1'b1, 2'd1},
    '{1'b0, 2'd0, 2'd1, 4'b0111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    '{1'b0, 2'd0, 2'd2, 4'b0111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0},
    '{1'b0, 2'd0, 2'd0, 4'b0111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    '{1'b0, 2'd0, 2'd0, 4'b0111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd2},
    '{1'b0, 2'd0, 2'd0, 4'b0111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd0},
    '{1'b0, 2'd0, 2'd0, 4'b0010, 4'b0010, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    '{1'b1, 2'd0, 2'd0, 4'b0010, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0},
    '{1'b0, 2'd0, 2'd0, 4'b0010, 4'b0000, 1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0},
    '{1'b0, 2'd0, 2'd0, 4'b0010, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1},
    '{1'b1, 2'd0, 2'd0, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 2'd0},
    '{1'b1, 2'd0, 2'd0, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic req, input logic [1:0] prio, input logic [1:0] md,
                       input logic [3:0] rdy, input logic [3:0] lst,
                       input logic cv, input logic [1:0] cl);
    @(negedge clk);
    allocReq = req; allocPrio = prio; mode = md;
    flitReady = rdy; flitLast = lst; creditValid = cv; creditLane = cl;
    #1;
  endtask

  function automatic int credOf(input int lane);
    return int'(laneCredit[lane*3 +: 3]);
  endfunction

  task automatic doReset();
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check(laneFree == 4'hF, "R1", "laneFree", laneFree, 15);
    check(laneCredit == {4{3'd4}}, "R1", "laneCredit", laneCredit, 2340);
    check(!creditErr && !sendValid, "R1", "err/send", {creditErr, sendValid}, 0);

    for (int v = 0; v < 14; v++) begin
      vec_t e;
      e = VECS[v];
      drive(e.req, e.prio, e.md, e.rdy, e.lst, e.cv, e.cl);
      check(allocGrant == e.expG && (!e.expG || allocLane == e.expGL), "R2/R3",
            $sformatf("vec %0d grant", v), {allocGrant, allocLane}, {e.expG, e.expGL});
      check(sendValid == e.expS && (!e.expS || sendLane == e.expSL), "R4/R5/R6/R7",
            $sformatf("vec %0d send", v), {sendValid, sendLane}, {e.expS, e.expSL});
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    // R8 counts after the table: lane0 1, lane1 0, lane2 3, lane3 4
    check(laneCredit == {3'd4, 3'd3, 3'd0, 3'd1}, "R8", "final credits",
          laneCredit, int'({3'd4, 3'd3, 3'd0, 3'd1}));
    check(laneFree == 4'b0000, "R2", "all busy", laneFree, 0);

    // R6 tie on priority falls back to rotation order
    doReset();
    drive(1, 2, 0, 0, 0, 0, 0);
    check(allocGrant && allocLane == 0, "R2", "tie alloc 0", allocLane, 0);
    drive(1, 2, 0, 0, 0, 0, 0);
    check(allocGrant && allocLane == 1, "R2", "tie alloc 1", allocLane, 1);
    drive(0, 0, 1, 4'b0011, 0, 0, 0);
    check(sendValid && sendLane == 0, "R6", "tie first", sendLane, 0);
    drive(0, 0, 1, 4'b0011, 0, 0, 0);
    check(sendValid && sendLane == 1, "R6", "tie second", sendLane, 1);

    // R8 send and credit on the same lane: lane0 count stays 3
    drive(0, 0, 0, 4'b0001, 0, 1, 0);
    check(sendValid && sendLane == 0, "R5", "wrap to lane0", sendLane, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check(credOf(0) == 3, "R8", "send+credit", credOf(0), 3);

    // R9 last flit releases lane1
    drive(0, 0, 0, 4'b0010, 4'b0010, 0, 0);
    check(sendValid && sendLane == 1, "R9", "last send", sendLane, 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    check(laneFree[1] == 1'b1, "R9", "lane1 free", laneFree[1], 1);
    check(credOf(1) == 2, "R8", "lane1 count", credOf(1), 2);

    // R10 overflow on full lane3
    drive(0, 0, 0, 0, 0, 1, 3);
    check(!creditErr, "R10", "err before edge", creditErr, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check(creditErr && credOf(3) == 4, "R10", "overflow", {creditErr, laneCredit[11:9]}, 12);
    drive(0, 0, 0, 0, 0, 0, 0);
    check(creditErr, "R10", "sticky", creditErr, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule